// File: doc/BRIEF.md
# Zone access rights evaluator

This block sits beside the bit-serial storage array of a protected card memory and decides, for the bit address currently selected, which of four operations the surrounding control logic may perform: read the bit, erase it (set its byte to ones), write it (clear it to zero), or feed it into a code comparison. It sorts the address into a memory zone. It then combines that zone with the security level, the flags raised by successful code checks elsewhere, and per-zone enables it keeps for itself. The result is four permission outputs plus a zone kind and an application index, which the sequencing and counter blocks use.

The security level comes from an external pin and a one-time internal fuse. The personalisation level applies only while the pin is high and the fuse is intact. In every other case the stricter field level applies. Each of the four application areas carries its own write enable and read enable, and these are copied from the area's first two data bits whenever the datapath reports those bits. The fuse is blown by a zero-write command anywhere in the fuse range, provided the master code has been validated. The fuse state is restored from non-volatile storage during reset.

Top module: `zone_rights_eval`

## Requirements
- R1: The personalisation level applies when `fuse_pin`=1 and the fuse is intact. Otherwise, including whenever the fuse is blown, the field level applies.
- R2: `zone_kind` encodes the zone as follows: 0 none, 1 factory (0..15), 2 issuer (16..79), 3 master code (80..95), 4 master attempt counter (96..103), 5 protected (104..167), 6 area code (16 bits), 7 area-1 code counter (8 bits, area 1 only), 8 erase key (16 bits), 9 erase counter (8 bits), 10 area data, 11 test (16040..16055), 12 fuse (16288..16303). Area codes start at 168, 9776, 11864 and 13952, and the fields of each area follow one another in that order. Area data runs up to 9775, 11863, 13951 and 16039. `zone_app` holds the area number minus one for kinds 6..10 and 0 otherwise. Kind 0 denies all four operations.
- R3: The area write enable and read enable are loaded from `bit_val` on a `bit_upd` cycle at the area's first and second data bit (216/217, 9816/9817, 11904/11905, 13992/13993). An update at any other address leaves them unchanged, and reset clears them.
- R4: The factory zone allows read only. The test zone allows read, write and erase but never compare.
- R5: The master code field allows only compare while `master_ok`=0, and read, write and erase while `master_ok`=1.
- R6: The protected zone is always readable, and write and erase need `master_ok`. The master attempt counter is always readable and writable, and erase needs `master_ok`.
- R7: At the personalisation level, every zone other than the factory, test, fuse and master fields allows read, write and erase when `master_ok`=1. When `master_ok`=0, the issuer zone, the protected zone and the counters allow read only, and the code fields, erase keys and area data allow nothing.
- R8: At the field level the issuer zone is read-only. An area code allows compare when `master_ok`=1 and `code_ok[n]`=0, and allows read, write and erase when both are set. The area-1 code counter is readable, writable with `master_ok`, and erasable with `master_ok` and `code_ok[0]`.
- R9: At the field level an erase key is never readable. It allows compare when `master_ok` and `code_ok[n]` are set and `erase_ok[n]`=0, and allows write and erase when all three are set. Its erase counter is readable, writable when `master_ok` and `code_ok[n]` are set, and erasable when `erase_ok[n]` is also set.
- R10: At the field level area data is readable when the read enable is set or when `master_ok` and `code_ok[n]` are both set. Writing additionally needs the write enable, and erasing needs `erase_ok[n]` as well.
- R11: The fuse range is always readable, writable only with `master_ok`, and never erasable or comparable. A `prog_go` cycle with `prog_val`=0 there while writing is allowed blows the fuse from the next cycle. The blown state holds until reset, and reset reloads it from `fuse_stored`.
- R12: Compare is never granted together with any other operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| addr | input | 14 | Currently selected bit address |
| fuse_pin | input | 1 | Level select pin (1 requests personalisation level) |
| fuse_stored | input | 1 | Non-volatile fuse state, loaded during reset (1 = blown) |
| master_ok | input | 1 | Master code validated |
| code_ok | input | 4 | Per-area code validated |
| erase_ok | input | 4 | Per-area erase key validated |
| bit_upd | input | 1 | Current bit value reported by datapath this cycle |
| bit_val | input | 1 | Reported bit value |
| prog_go | input | 1 | Programming command executes this cycle |
| prog_val | input | 1 | Programmed value (0 write, 1 erase) |
| may_read | output | 1 | Read allowed |
| may_erase | output | 1 | Erase allowed |
| may_write | output | 1 | Write allowed |
| may_compare | output | 1 | Compare allowed |
| zone_kind | output | 4 | Zone kind code per R2 |
| zone_app | output | 2 | Area index per R2 |

## Verification
The bench builds the block with its default map: a 14-bit address and four application areas. At that size every one of the 16384 addresses can be swept in each of five combinations of level pin, master flag and per-area code and erase flags, with the loaded area enables set to a mixed pattern. Every zone boundary, every decode gap and every row of the rights table is therefore checked against an independent range-and-rule model. Directed sequences then cover enable capture, fuse blowing with and without master validation, and the fuse reload on reset.

// File: rtl/zre_pkg.sv
package zre_pkg;

    localparam int ADDR_W = 14;
    localparam int N_APP  = 4;
    localparam int IDX_W  = $clog2(N_APP);

    localparam int unsigned FAB_HI   = 15;
    localparam int unsigned ISS_HI   = 79;
    localparam int unsigned MCODE_HI = 95;
    localparam int unsigned MCNT_HI  = 103;
    localparam int unsigned CPZ_HI   = 167;
    localparam int unsigned TEST_LO  = 16040;
    localparam int unsigned TEST_HI  = 16055;
    localparam int unsigned FUSE_LO  = 16288;
    localparam int unsigned FUSE_HI  = 16303;
    localparam int unsigned CODE_W   = 16;
    localparam int unsigned CNT_W    = 8;

    localparam int unsigned CODE_LO [N_APP] = '{168, 9776, 11864, 13952};
    localparam int unsigned DATA_HI [N_APP] = '{9775, 11863, 13951, 16039};
    localparam logic [N_APP-1:0] HAS_CODE_CNT = 4'b0001;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [3:0] {
        Z_NONE  = 4'd0,
        Z_FAB   = 4'd1,
        Z_ISS   = 4'd2,
        Z_MCODE = 4'd3,
        Z_MCNT  = 4'd4,
        Z_CPZ   = 4'd5,
        Z_ACODE = 4'd6,
        Z_ACNT  = 4'd7,
        Z_EKEY  = 4'd8,
        Z_ECNT  = 4'd9,
        Z_APP   = 4'd10,
        Z_TEST  = 4'd11,
        Z_FUSE  = 4'd12
    } zone_e;

    typedef struct packed {
        zone_e            kind;
        logic [IDX_W-1:0] idx;
        logic             at_wen;
        logic             at_ren;
    } zone_t;

    typedef struct packed {
        logic rd;
        logic er;
        logic wr;
        logic cm;
    } perm_t;

    function automatic zone_t decode(input addr_t a);
        zone_t       z;
        int unsigned u;
        u = 32'(a);
        z = '{kind: Z_NONE, idx: '0, at_wen: 1'b0, at_ren: 1'b0};
        if (u <= FAB_HI)                      z.kind = Z_FAB;
        else if (u <= ISS_HI)                 z.kind = Z_ISS;
        else if (u <= MCODE_HI)               z.kind = Z_MCODE;
        else if (u <= MCNT_HI)                z.kind = Z_MCNT;
        else if (u <= CPZ_HI)                 z.kind = Z_CPZ;
        else if (u >= TEST_LO && u <= TEST_HI) z.kind = Z_TEST;
        else if (u >= FUSE_LO && u <= FUSE_HI) z.kind = Z_FUSE;
        else begin
            for (int i = 0; i < N_APP; i++) begin
                int unsigned c;
                int unsigned k;
                c = CODE_LO[i];
                k = c + CODE_W + (HAS_CODE_CNT[i] ? CNT_W : 0);
                if (u >= c && u < c + CODE_W) begin
                    z.kind = Z_ACODE; z.idx = IDX_W'(i);
                end else if (HAS_CODE_CNT[i] && u >= c + CODE_W && u < k) begin
                    z.kind = Z_ACNT; z.idx = IDX_W'(i);
                end else if (u >= k && u < k + CODE_W) begin
                    z.kind = Z_EKEY; z.idx = IDX_W'(i);
                end else if (u >= k + CODE_W && u < k + CODE_W + CNT_W) begin
                    z.kind = Z_ECNT; z.idx = IDX_W'(i);
                end else if (u >= k + CODE_W + CNT_W && u <= DATA_HI[i]) begin
                    z.kind   = Z_APP; z.idx = IDX_W'(i);
                    z.at_wen = (u == k + CODE_W + CNT_W);
                    z.at_ren = (u == k + CODE_W + CNT_W + 1);
                end
            end
        end
        return z;
    endfunction

    function automatic perm_t grant(input zone_e k, input logic lvl1, input logic sv,
                                    input logic sn, input logic en,
                                    input logic pn, input logic rn);
        perm_t g;
        g = '0;
        case (k)
            Z_FAB:   g.rd = 1'b1;
            Z_ISS:   begin g.rd = 1'b1; g.er = lvl1 & sv; g.wr = lvl1 & sv; end
            Z_MCODE: begin g.rd = sv; g.er = sv; g.wr = sv; g.cm = ~sv; end
            Z_MCNT:  begin g.rd = 1'b1; g.wr = 1'b1; g.er = sv; end
            Z_CPZ:   begin g.rd = 1'b1; g.wr = sv; g.er = sv; end
            Z_ACODE: begin
                g.cm = ~lvl1 & sv & ~sn;
                g.rd = sv & (lvl1 | sn);
                g.er = g.rd; g.wr = g.rd;
            end
            Z_ACNT:  begin g.rd = 1'b1; g.wr = sv; g.er = sv & (lvl1 | sn); end
            Z_EKEY:  begin
                g.cm = ~lvl1 & sv & sn & ~en;
                g.rd = lvl1 & sv;
                g.wr = sv & (lvl1 | (sn & en));
                g.er = g.wr;
            end
            Z_ECNT:  begin
                g.rd = 1'b1;
                g.wr = sv & (lvl1 | sn);
                g.er = sv & (lvl1 | (sn & en));
            end
            Z_APP:   begin
                if (lvl1) begin
                    g.rd = sv; g.wr = sv; g.er = sv;
                end else begin
                    g.rd = rn | (sv & sn);
                    g.wr = sv & sn & pn;
                    g.er = sv & sn & pn & en;
                end
            end
            Z_TEST:  begin g.rd = 1'b1; g.wr = 1'b1; g.er = 1'b1; end
            Z_FUSE:  begin g.rd = 1'b1; g.wr = sv; end
            default: g = '0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/zre_decode.sv
module zre_decode
    import zre_pkg::*;
(
    input  addr_t addr,
    output zone_t zone
);
    always_comb zone = decode(addr);
endmodule

// File: rtl/zre_flags.sv
module zre_flags
    import zre_pkg::*;
#(
    parameter int N = N_APP
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fuse_stored,
    input  zone_t        zone,
    input  logic         bit_upd,
    input  logic         bit_val,
    input  logic         blow_req,
    output logic [N-1:0] wen,
    output logic [N-1:0] ren,
    output logic         blown
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wen   <= '0;
            ren   <= '0;
            blown <= fuse_stored;
        end else begin
            if (bit_upd && zone.kind == Z_APP) begin
                if (zone.at_wen) wen[zone.idx] <= bit_val;
                if (zone.at_ren) ren[zone.idx] <= bit_val;
            end
            if (blow_req) blown <= 1'b1;
        end
    end
endmodule

// File: rtl/zre_rights.sv
module zre_rights
    import zre_pkg::*;
#(
    parameter int N = N_APP
) (
    input  zone_t        zone,
    input  logic         lvl1,
    input  logic         master_ok,
    input  logic [N-1:0] code_ok,
    input  logic [N-1:0] erase_ok,
    input  logic [N-1:0] wen,
    input  logic [N-1:0] ren,
    output perm_t        perm
);
    always_comb
        perm = grant(zone.kind, lvl1, master_ok, code_ok[zone.idx],
                     erase_ok[zone.idx], wen[zone.idx], ren[zone.idx]);
endmodule

// File: rtl/zone_rights_eval.sv
module zone_rights_eval
    import zre_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic             fuse_pin,
    input  logic             fuse_stored,
    input  logic             master_ok,
    input  logic [N_APP-1:0] code_ok,
    input  logic [N_APP-1:0] erase_ok,
    input  logic             bit_upd,
    input  logic             bit_val,
    input  logic             prog_go,
    input  logic             prog_val,
    output logic             may_read,
    output logic             may_erase,
    output logic             may_write,
    output logic             may_compare,
    output logic [3:0]       zone_kind,
    output logic [IDX_W-1:0] zone_app
);
    zone_t            zone;
    perm_t            perm;
    logic [N_APP-1:0] wen, ren;
    logic             fuse_blown;
    logic             lvl1;
    logic             blow_req;

    zre_decode u_decode (.addr(addr), .zone(zone));

    assign lvl1     = fuse_pin & ~fuse_blown;
    assign blow_req = prog_go & ~prog_val & perm.wr & (zone.kind == Z_FUSE);

    zre_flags #(.N(N_APP)) u_flags (
        .clk(clk), .rst(rst), .fuse_stored(fuse_stored), .zone(zone),
        .bit_upd(bit_upd), .bit_val(bit_val), .blow_req(blow_req),
        .wen(wen), .ren(ren), .blown(fuse_blown)
    );

    zre_rights #(.N(N_APP)) u_rights (
        .zone(zone), .lvl1(lvl1), .master_ok(master_ok), .code_ok(code_ok),
        .erase_ok(erase_ok), .wen(wen), .ren(ren), .perm(perm)
    );

    assign may_read    = perm.rd;
    assign may_erase   = perm.er;
    assign may_write   = perm.wr;
    assign may_compare = perm.cm;
    assign zone_kind   = zone.kind;
    assign zone_app    = zone.idx;
endmodule

// File: rtl/zre_chk.sv
module zre_chk
    import zre_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [3:0] zone_kind,
    input logic       rd,
    input logic       er,
    input logic       wr,
    input logic       cm,
    input logic       fuse_pin,
    input logic       blown,
    input logic       master_ok,
    input logic       prog_go,
    input logic       prog_val
);
    p_fab_readonly_r4: assert property (@(posedge clk) disable iff (rst)
        zone_kind == 4'(Z_FAB) |-> rd && !wr && !er && !cm);

    p_test_open_r4: assert property (@(posedge clk) disable iff (rst)
        zone_kind == 4'(Z_TEST) |-> rd && wr && er && !cm);

    p_none_denies_r2: assert property (@(posedge clk) disable iff (rst)
        zone_kind == 4'(Z_NONE) |-> !rd && !wr && !er && !cm);

    p_cmp_alone_r12: assert property (@(posedge clk) disable iff (rst)
        cm |-> !rd && !wr && !er);

    p_issuer_locked_r8: assert property (@(posedge clk) disable iff (rst)
        (zone_kind == 4'(Z_ISS) && (!fuse_pin || blown)) |-> !wr && !er);

    p_fuse_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(blown) |-> blown);

    p_fuse_cause_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $rose(blown) |-> $past(master_ok && prog_go && !prog_val));
endmodule

bind zone_rights_eval zre_chk i_zre_chk (
    .clk(clk), .rst(rst), .zone_kind(zone_kind),
    .rd(may_read), .er(may_erase), .wr(may_write), .cm(may_compare),
    .fuse_pin(fuse_pin), .blown(fuse_blown), .master_ok(master_ok),
    .prog_go(prog_go), .prog_val(prog_val)
);

// File: tb/test_zone_rights_eval.sv
module test_zone_rights_eval;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst, fuse_pin, fuse_stored, master_ok;
    logic [13:0] addr;
    logic [3:0]  code_ok, erase_ok;
    logic        bit_upd, bit_val, prog_go, prog_val;
    logic        may_read, may_erase, may_write, may_compare;
    logic [3:0]  zone_kind;
    logic [1:0]  zone_app;

    int checks = 0;
    int errors = 0;
    logic [3:0] pexp, rexp;
    int dbase [4] = '{216, 9816, 11904, 13992};
    int cbase [4] = '{168, 9776, 11864, 13952};

    zone_rights_eval i_zone_rights_eval (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s @addr %0d: actual %0d expected %0d", req, what, addr, act, exp);
        end
    endtask

    task automatic report;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // zone kind and area index from the address map, computed per range
    function automatic void exp_zone(input int a, output int k, output int ix);
        k = 0; ix = 0;
        if (a < 16) k = 1;
        else if (a < 80) k = 2;
        else if (a < 96) k = 3;
        else if (a < 104) k = 4;
        else if (a < 168) k = 5;
        else if (a >= 16040 && a < 16056) k = 11;
        else if (a >= 16288 && a < 16304) k = 12;
        else if (a < 16040) begin
            for (int i = 0; i < 4; i++) begin
                int c, ek, hi;
                c  = cbase[i];
                ek = c + ((i == 0) ? 24 : 16);
                hi = (i < 3) ? cbase[i+1] - 1 : 16039;
                if (a >= c && a <= hi) begin
                    ix = i;
                    if (a < c + 16) k = 6;
                    else if (a < ek) k = 7;
                    else if (a < ek + 16) k = 8;
                    else if (a < ek + 24) k = 9;
                    else k = 10;
                end
            end
        end
    endfunction

    // {read, erase, write, compare}
    function automatic logic [3:0] exp_perm(input int k, input int ix, input logic l1,
                                            input logic sv, input logic [3:0] s,
                                            input logic [3:0] e);
        logic sn, en, pn, rn;
        sn = s[ix]; en = e[ix]; pn = pexp[ix]; rn = rexp[ix];
        case (k)
            1:  return 4'b1000;
            2:  return (l1 && sv) ? 4'b1110 : 4'b1000;
            3:  return sv ? 4'b1110 : 4'b0001;
            4:  return sv ? 4'b1110 : 4'b1010;
            5:  return sv ? 4'b1110 : 4'b1000;
            6:  if (l1) return sv ? 4'b1110 : 4'b0000;
                else if (!sv) return 4'b0000;
                else return sn ? 4'b1110 : 4'b0001;
            7:  if (l1) return sv ? 4'b1110 : 4'b1000;
                else return {1'b1, sv && sn, sv, 1'b0};
            8:  if (l1) return sv ? 4'b1110 : 4'b0000;
                else if (!(sv && sn)) return 4'b0000;
                else return en ? 4'b0110 : 4'b0001;
            9:  if (l1) return sv ? 4'b1110 : 4'b1000;
                else return {1'b1, sv && sn && en, sv && sn, 1'b0};
            10: if (l1) return sv ? 4'b1110 : 4'b0000;
                else return {rn || (sv && sn), sv && sn && pn && en, sv && sn && pn, 1'b0};
            11: return 4'b1110;
            12: return {1'b1, 1'b0, sv, 1'b0};
            default: return 4'b0000;
        endcase
    endfunction

    function automatic string tag(input int k, input logic l1);
        case (k)
            1, 11:  return "R4";
            3:      return "R5";
            4, 5:   return "R6";
            12:     return "R11";
            2, 6, 7: return l1 ? "R7" : "R8";
            8, 9:   return l1 ? "R7" : "R9";
            10:     return l1 ? "R7" : "R10";
            default: return "R2";
        endcase
    endfunction

    task automatic sweep(input logic pin, input logic sv, input logic [3:0] s, input logic [3:0] e);
        int k, ix;
        logic [3:0] ep;
        @(negedge clk);
        fuse_pin = pin; master_ok = sv; code_ok = s; erase_ok = e;
        for (int a = 0; a < 16384; a++) begin
            @(negedge clk);
            addr = 14'(a);
            #1;
            exp_zone(a, k, ix);
            chk("R2", "zone", {zone_kind, zone_app}, {4'(k), 2'(ix)});
            ep = exp_perm(k, ix, pin, sv, s, e);
            chk(tag(k, pin), "perm", {may_read, may_erase, may_write, may_compare}, ep);
            chk("R12", "cmp exclusive", int'(may_compare && (may_read || may_erase || may_write)), 0);
        end
    endtask

    task automatic load_bit(input int a, input logic v);
        @(negedge clk);
        addr = 14'(a); bit_val = v; bit_upd = 1'b1;
        @(negedge clk);
        bit_upd = 1'b0;
    endtask

    task automatic prog(input int a, input logic v);
        @(negedge clk);
        addr = 14'(a); prog_val = v; prog_go = 1'b1;
        @(negedge clk);
        prog_go = 1'b0;
    endtask

    task automatic do_reset(input logic stored);
        fuse_stored = stored; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        pexp = '0; rexp = '0;
    endtask

    task automatic look(input int a);
        @(negedge clk);
        addr = 14'(a);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        rst = 1'b1; addr = '0; fuse_pin = 1'b0; fuse_stored = 1'b0; master_ok = 1'b0;
        code_ok = '0; erase_ok = '0; bit_upd = 1'b0; bit_val = 1'b0;
        prog_go = 1'b0; prog_val = 1'b0;
        do_reset(1'b0);

        // reset state
        look(217); chk("R3", "read after reset", may_read, 0);
        look(80);  chk("R5", "compare code before validation", may_compare, 1);
        look(0);   chk("R4", "factory read", may_read, 1);

        // enable capture
        pexp = 4'b1010; rexp = 4'b0110;
        for (int i = 0; i < 4; i++) begin
            load_bit(dbase[i], pexp[i]);
            load_bit(dbase[i] + 1, rexp[i]);
        end
        for (int i = 0; i < 4; i++) begin
            look(dbase[i] + 5);
            chk("R3", "read enable captured", may_read, int'(rexp[i]));
        end
        load_bit(dbase[1] + 3, 1'b0);
        look(dbase[1] + 7);
        chk("R3", "other bit leaves enable", may_read, 1);

        // full-map sweeps
        sweep(1'b1, 1'b0, 4'b0000, 4'b0000);
        sweep(1'b1, 1'b1, 4'b0000, 4'b0000);
        sweep(1'b0, 1'b0, 4'b1111, 4'b1111);
        sweep(1'b0, 1'b1, 4'b0101, 4'b0011);
        sweep(1'b0, 1'b1, 4'b1111, 4'b1100);

        // fuse handling
        fuse_pin = 1'b1; master_ok = 1'b0; code_ok = '0; erase_ok = '0;
        prog(16290, 1'b0);
        master_ok = 1'b1;
        look(20); chk("R11", "no blow without master", may_write, 1);
        prog(16303, 1'b1);
        look(20); chk("R11", "erase does not blow", may_write, 1);
        prog(16300, 1'b0);
        look(20); chk("R1", "blown fuse forces field level", may_write, 0);
        fuse_pin = 1'b0; look(20); fuse_pin = 1'b1; #1;
        chk("R11", "blown state sticks", may_write, 0);
        do_reset(1'b0);
        look(20); chk("R11", "reset reloads intact fuse", may_write, 1);
        fuse_pin = 1'b0; #1;
        chk("R1", "low pin gives field level", may_write, 0);
        fuse_pin = 1'b1;
        do_reset(1'b1);
        look(20); chk("R11", "reset reloads blown fuse", may_write, 0);

        report();
    end
endmodule